// File: doc/BRIEF.md
# Transceiver Interrupt Status and Mask Unit

This unit gathers eight event sources from a transceiver's link, jabber and auto-negotiation machinery and turns them into a single interrupt pin. Every source has a sticky status flag and a matching enable flag. A status flag records its event even when the enable flag is clear. The enable flag only decides whether that flag can drive the pin.

Six of the sources arrive as single-cycle pulses. The receive-error source arrives as a level and counts only on its rising edge. The link source arrives as a 2-bit state and counts only when the state leaves OK. Management logic reads the combined register through a read strobe, and that read clears every status flag. It writes the enable flags through a write port and selects the pin polarity through a separate control write.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset all enable flags and all status flags are 0 and the polarity bit is 0, so `irq_o` is 1 (inactive for the active-low setting).
- R2: `rd_data_o` shows the enable flags in bits 15..8 and the status flags in bits 7..0. Both bytes use the same source order, from the top bit down: jabber (7), receive error (6), page received (5), parallel-detection fault (4), partner acknowledge (3), link went down (2), remote fault (1), negotiation complete (0).
- R3: When `wr_stb_i` is high, the enable flags take `wr_data_i[15:8]` at the next edge. `wr_data_i[7:0]` has no effect on any flag.
- R4: A status flag stays set until a cycle in which `rd_stb_i` is high. That cycle's `rd_data_o` shows the flags before they clear, and they are 0 from the next cycle on.
- R5: If a source event occurs in the same cycle as a clearing read, its status flag is set after that edge and the event is not lost.
- R6: The receive-error flag is set only in a cycle where `rx_err_i` is 1 and it was 0 in the previous cycle, or 0 since reset. Holding the input high does not set the flag again after it has been cleared.
- R7: `link_state_i` is coded 00 fail, 01 ready, 10 OK and 11 other (not OK). The link flag is set only in a cycle where the previous state was OK and the current state is not OK. The state seen during reset counts as fail.
- R8: A status flag records its event whether or not its enable flag is set.
- R9: The interrupt is active whenever at least one status flag and its enable flag are both 1. It is inactive once no such pair remains.
- R10: The polarity bit is loaded from `pol_high_i` when `pol_wr_i` is high. When the bit is 1 the active level of `irq_o` is 1; when it is 0 the active level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jabber_i | input | 1 | Jabber event pulse |
| rx_err_i | input | 1 | Receive-error level; counted on its rising edge |
| page_rx_i | input | 1 | Page received event pulse |
| pd_fault_i | input | 1 | Parallel-detection fault event pulse |
| lp_ack_i | input | 1 | Link-partner acknowledge event pulse |
| link_state_i | input | 2 | Link state: 00 fail, 01 ready, 10 OK, 11 other |
| rem_fault_i | input | 1 | Remote fault event pulse |
| an_done_i | input | 1 | Negotiation complete event pulse |
| rd_stb_i | input | 1 | Register read strobe; clears status flags |
| rd_data_o | output | 16 | Enable flags (15..8) and status flags (7..0) |
| wr_stb_i | input | 1 | Enable-flag write strobe |
| wr_data_i | input | 16 | Write data; bits 15..8 go to the enable flags |
| pol_wr_i | input | 1 | Polarity bit write strobe |
| pol_high_i | input | 1 | Polarity value: 1 active-high, 0 active-low |
| irq_o | output | 1 | Interrupt pin |

## Verification
The bench builds the block with its defaults: eight sources and a 16-bit register. With that width every source position is reachable, including the two edge-derived ones at bits 6 and 2. Directed phases drive reads that coincide with events, a receive-error level held high across several reads, and every transition of the link state. A long randomized phase then mixes writes, polarity changes and reads against a behavioural model.

// File: rtl/phy_irq_pkg.sv
// Package: shared constants for the transceiver interrupt unit.
// Fixes the number of sources, the register width and the bit position of
// each source inside the status and enable bytes. Assumes one source per bit.
package phy_irq_pkg;
    localparam int SRC_N = 8;
    localparam int REG_W = 2 * SRC_N;

    // Position of each source within a byte (status and enable alike)
    localparam int SB_JAB    = 7;
    localparam int SB_RXERR  = 6;
    localparam int SB_PAGE   = 5;
    localparam int SB_PDF    = 4;
    localparam int SB_LPACK  = 3;
    localparam int SB_LINKDN = 2;
    localparam int SB_RFLT   = 1;
    localparam int SB_ANDONE = 0;

    typedef enum logic [1:0] {
        LNK_FAIL  = 2'b00,
        LNK_READY = 2'b01,
        LNK_OK    = 2'b10,
        LNK_OTHER = 2'b11
    } link_st_e;
endpackage

// File: rtl/phy_irq_trans.sv
// Module: transition detector for level-type event sources.
// RISE_MODE=1: one-cycle hit when bit 0 of lvl_i goes from 0 to 1.
// RISE_MODE=0: one-cycle hit when lvl_i leaves the code HOLD_CODE.
// The remembered previous value resets to all zeros.
module phy_irq_trans #(
    parameter int          W         = 1,
    parameter bit          RISE_MODE = 1'b1,
    parameter logic [W-1:0] HOLD_CODE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic         hit_o
);
    logic [W-1:0] prev_q;

    // Remember the level seen in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    generate
        if (RISE_MODE) begin : g_rise
            logic unused_hi;
            if (W > 1) begin : g_wide
                assign unused_hi = ^{lvl_i[W-1:1], prev_q[W-1:1]};
            end else begin : g_narrow
                assign unused_hi = 1'b0;
            end
            // Rising edge of the least significant bit
            always_comb hit_o = lvl_i[0] & ~prev_q[0];
        end else begin : g_leave
            // Leaving the held code for any other code
            always_comb hit_o = (prev_q == HOLD_CODE) && (lvl_i != HOLD_CODE);
        end
    endgenerate
endmodule

// File: rtl/phy_irq_bank.sv
// Module: sticky status flags and enable flags, one pair per source.
// Assumes set_i is a one-cycle request per source and rd_clr_i marks a
// register read; a set request wins over a clear in the same cycle.
module phy_irq_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         rd_clr_i,
    input  logic         en_wr_i,
    input  logic [N-1:0] en_data_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] st_o
);
    logic [N-1:0] en_q;
    logic [N-1:0] st_q;

    // Enable flags: loaded by the write port
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= en_data_i;
    end

    // Status flags: one sticky flop per source, set beats clear
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n)        st_q[i] <= 1'b0;
                else if (set_i[i]) st_q[i] <= 1'b1;
                else if (rd_clr_i) st_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign en_o = en_q;
    assign st_o = st_q;

    // R4: a read clears every flag that had no new event
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> ((st_q & ~$past(set_i)) == '0));
    // R4: without a read, set flags stay set
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((st_q & $past(st_q)) == $past(st_q)));
    // R5: an event is captured even during a clearing read
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i)));
    // R8: a flag never appears without its event, whatever the enable
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~$past(st_q) & ~$past(set_i)) == '0));
    // R3: a write loads the enable flags
    assert_enable_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_q == $past(en_data_i)));
endmodule

// File: rtl/phy_irq_pin.sv
// Module: interrupt pin driver with a programmable polarity bit.
// Combines enable and status flags into one request and applies the
// polarity held in a local register (reset 0 = active-low).
module phy_irq_pin #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pol_wr_i,
    input  logic         pol_d_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] st_i,
    output logic         irq_o
);
    logic pol_q;
    logic req;

    // Polarity bit: loaded by its own write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        pol_q <= 1'b0;
        else if (pol_wr_i) pol_q <= pol_d_i;
    end

    // Request when any enabled flag is set; apply polarity
    always_comb begin
        req   = |(en_i & st_i);
        irq_o = pol_q ? req : ~req;
    end

    // R10: the polarity bit changes only through its write strobe
    assert_pol_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_wr_i |=> $stable(pol_q));
    assert_pol_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pol_wr_i |=> (pol_q == $past(pol_d_i)));
endmodule

// File: rtl/phy_irq_ctrl.sv
// Module: top of the transceiver interrupt unit.
// Maps eight event sources onto sticky status flags, masks them with
// enable flags and drives one interrupt pin. Assumes pulse sources are
// one cycle wide; receive error and link state are levels.
module phy_irq_ctrl
    import phy_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             jabber_i,
    input  logic             rx_err_i,
    input  logic             page_rx_i,
    input  logic             pd_fault_i,
    input  logic             lp_ack_i,
    input  logic [1:0]       link_state_i,
    input  logic             rem_fault_i,
    input  logic             an_done_i,
    input  logic             rd_stb_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             wr_stb_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             pol_wr_i,
    input  logic             pol_high_i,
    output logic             irq_o
);
    logic             rx_rise;
    logic             link_drop;
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] en_vec;
    logic [SRC_N-1:0] st_vec;
    logic             unused_wr_lo;

    assign unused_wr_lo = ^wr_data_i[SRC_N-1:0];

    phy_irq_trans #(.W(1), .RISE_MODE(1'b1), .HOLD_CODE(1'b0)) u_rx_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (rx_err_i),
        .hit_o (rx_rise)
    );

    phy_irq_trans #(.W(2), .RISE_MODE(1'b0), .HOLD_CODE(LNK_OK)) u_link_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (link_state_i),
        .hit_o (link_drop)
    );

    // Gather the per-source set requests at their fixed positions
    always_comb begin
        set_vec            = '0;
        set_vec[SB_JAB]    = jabber_i;
        set_vec[SB_RXERR]  = rx_rise;
        set_vec[SB_PAGE]   = page_rx_i;
        set_vec[SB_PDF]    = pd_fault_i;
        set_vec[SB_LPACK]  = lp_ack_i;
        set_vec[SB_LINKDN] = link_drop;
        set_vec[SB_RFLT]   = rem_fault_i;
        set_vec[SB_ANDONE] = an_done_i;
    end

    phy_irq_bank #(.N(SRC_N)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .rd_clr_i  (rd_stb_i),
        .en_wr_i   (wr_stb_i),
        .en_data_i (wr_data_i[REG_W-1:SRC_N]),
        .en_o      (en_vec),
        .st_o      (st_vec)
    );

    phy_irq_pin #(.N(SRC_N)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pol_wr_i (pol_wr_i),
        .pol_d_i  (pol_high_i),
        .en_i     (en_vec),
        .st_i     (st_vec),
        .irq_o    (irq_o)
    );

    assign rd_data_o = {en_vec, st_vec};

    // R6: the receive-error flag rises only after the input was high
    assert_rx_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vec[SB_RXERR] && !$past(st_vec[SB_RXERR])) |-> $past(rx_err_i));
    // R7: the link flag rises only after a non-OK state was presented
    assert_link_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vec[SB_LINKDN] && !$past(st_vec[SB_LINKDN])) |-> ($past(link_state_i) != LNK_OK));
endmodule

// File: tb/sim_phy_irq_ctrl.sv
`timescale 1ns/1ps
module sim_phy_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jabber_i = 0, rx_err_i = 0, page_rx_i = 0, pd_fault_i = 0;
    logic        lp_ack_i = 0, rem_fault_i = 0, an_done_i = 0;
    logic [1:0]  link_state_i = 2'b00;
    logic        rd_stb_i = 0, wr_stb_i = 0, pol_wr_i = 0, pol_high_i = 0;
    logic [15:0] wr_data_i = 16'h0;
    logic [15:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_en = 0, m_st = 0, m_pol = 0, m_prev_rx = 0, m_prev_link = 0;

    always #10 clk = ~clk;

    phy_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .jabber_i(jabber_i), .rx_err_i(rx_err_i),
        .page_rx_i(page_rx_i), .pd_fault_i(pd_fault_i), .lp_ack_i(lp_ack_i),
        .link_state_i(link_state_i), .rem_fault_i(rem_fault_i), .an_done_i(an_done_i),
        .rd_stb_i(rd_stb_i), .rd_data_o(rd_data_o), .wr_stb_i(wr_stb_i),
        .wr_data_i(wr_data_i), .pol_wr_i(pol_wr_i), .pol_high_i(pol_high_i),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int exp_pin();
        int act;
        act = ((m_en & m_st) != 0) ? 1 : 0;
        return m_pol ? act : 1 - act;
    endfunction

    task automatic compare_all();
        check(cur_req, int'(rd_data_o), (m_en << 8) | m_st);
        check(cur_req, int'(irq_o), exp_pin());
    endtask

    // one clock: model next state from driven inputs, then compare
    task automatic tick();
        int set;
        int rx;
        int lk;
        rx  = int'(rx_err_i);
        lk  = int'(link_state_i);
        set = (int'(jabber_i) << 7) | (((rx == 1 && m_prev_rx == 0) ? 1 : 0) << 6)
            | (int'(page_rx_i) << 5) | (int'(pd_fault_i) << 4) | (int'(lp_ack_i) << 3)
            | (((m_prev_link == 2 && lk != 2) ? 1 : 0) << 2)
            | (int'(rem_fault_i) << 1) | int'(an_done_i);
        @(posedge clk);
        m_st = (rd_stb_i ? 0 : m_st) | set;
        if (wr_stb_i) m_en = int'(wr_data_i[15:8]);
        if (pol_wr_i) m_pol = int'(pol_high_i);
        m_prev_rx = rx;
        m_prev_link = lk;
        @(negedge clk);
        compare_all();
        jabber_i = 0; page_rx_i = 0; pd_fault_i = 0; lp_ack_i = 0;
        rem_fault_i = 0; an_done_i = 0; rd_stb_i = 0; wr_stb_i = 0; pol_wr_i = 0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state read at the ports
        check("R1", int'(rd_data_o), 0);
        check("R1", int'(irq_o), 1);

        // R2: layout of enable and status bytes
        cur_req = "R2";
        wr_stb_i = 1; wr_data_i = 16'hFF00; tick();
        jabber_i = 1; tick();
        check("R2", int'(rd_data_o), 16'hFF80);
        an_done_i = 1; tick();
        check("R2", int'(rd_data_o), 16'hFF81);
        lp_ack_i = 1; pd_fault_i = 1; tick();
        check("R2", int'(rd_data_o), 16'hFF99);

        // R4: read shows old value, then clears
        cur_req = "R4";
        rd_stb_i = 1;
        check("R4", int'(rd_data_o[7:0]), 8'h99);
        tick();
        check("R4", int'(rd_data_o[7:0]), 0);

        // R3: enable write uses the high byte only
        cur_req = "R3";
        rem_fault_i = 1; tick();
        wr_stb_i = 1; wr_data_i = 16'hA5FF; tick();
        check("R3", int'(rd_data_o), 16'hA502);

        // R5: event during a clearing read survives
        cur_req = "R5";
        rd_stb_i = 1; page_rx_i = 1; tick();
        check("R5", int'(rd_data_o[7:0]), 8'h20);
        rd_stb_i = 1; tick();

        // R6: receive error counts on its rising edge only
        cur_req = "R6";
        rx_err_i = 1; tick();
        check("R6", int'(rd_data_o[6]), 1);
        rd_stb_i = 1; tick();
        tick(); tick();
        check("R6", int'(rd_data_o[6]), 0);
        rx_err_i = 0; tick();
        rx_err_i = 1; tick();
        check("R6", int'(rd_data_o[6]), 1);
        rx_err_i = 0; rd_stb_i = 1; tick();

        // R7: link flag only when leaving OK
        cur_req = "R7";
        link_state_i = 2'b01; tick();
        link_state_i = 2'b10; tick();
        check("R7", int'(rd_data_o[2]), 0);
        link_state_i = 2'b01; tick();
        check("R7", int'(rd_data_o[2]), 1);
        rd_stb_i = 1; link_state_i = 2'b00; tick();
        check("R7", int'(rd_data_o[2]), 0);
        link_state_i = 2'b10; tick();
        link_state_i = 2'b11; tick();
        check("R7", int'(rd_data_o[2]), 1);
        rd_stb_i = 1; link_state_i = 2'b10; tick();
        link_state_i = 2'b00; tick();
        check("R7", int'(rd_data_o[2]), 1);
        rd_stb_i = 1; tick();

        // R8: flags record with enables clear; pin stays inactive
        cur_req = "R8";
        wr_stb_i = 1; wr_data_i = 16'h0000; tick();
        jabber_i = 1; pd_fault_i = 1; tick();
        check("R8", int'(rd_data_o[7:0]), 8'h90);
        check("R8", int'(irq_o), 1);

        // R9: enabling a set flag asserts the pin, read releases it
        cur_req = "R9";
        wr_stb_i = 1; wr_data_i = 16'h1000; tick();
        check("R9", int'(irq_o), 0);
        rd_stb_i = 1; tick();
        check("R9", int'(irq_o), 1);

        // R10: polarity select
        cur_req = "R10";
        pol_wr_i = 1; pol_high_i = 1; tick();
        check("R10", int'(irq_o), 0);
        pd_fault_i = 1; tick();
        check("R10", int'(irq_o), 1);
        pol_wr_i = 1; pol_high_i = 0; tick();
        check("R10", int'(irq_o), 0);

        // R9: randomized mix against the model
        cur_req = "R9";
        void'($urandom(32'h1234));
        for (int i = 0; i < 3000; i++) begin
            jabber_i    = ($urandom_range(7) == 0);
            page_rx_i   = ($urandom_range(7) == 0);
            pd_fault_i  = ($urandom_range(7) == 0);
            lp_ack_i    = ($urandom_range(7) == 0);
            rem_fault_i = ($urandom_range(7) == 0);
            an_done_i   = ($urandom_range(7) == 0);
            if ($urandom_range(3) == 0) rx_err_i = ~rx_err_i;
            if ($urandom_range(3) == 0) link_state_i = 2'($urandom_range(3));
            rd_stb_i    = ($urandom_range(5) == 0);
            wr_stb_i    = ($urandom_range(9) == 0);
            wr_data_i   = 16'($urandom);
            pol_wr_i    = ($urandom_range(19) == 0);
            pol_high_i  = 1'($urandom_range(1));
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule